// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block keeps track of transmit requests raised by a small set of mailboxes and decides which of the waiting mailboxes the CAN protocol engine serves next. A mailbox is armed by a one-cycle request strobe that carries an 11-bit identifier. The scheduler offers one mailbox and its identifier to the engine through a valid/ready handshake. It then waits for a completion that reports the outcome of that attempt.

Two run-time controls shape the behaviour. `order_fifo` chooses between identifier priority, where the numerically lowest identifier wins, and request-age order, where the oldest request wins. `one_shot` decides what happens after a failed attempt. When it is clear, the mailbox stays armed and is retried. When it is set, the mailbox is retired after its single attempt, whatever the outcome. Each mailbox reports three flags: pending, sent-successfully and finished.

Top module: `can_tx_sched`

## Requirements
- R1: While reset is applied and in the first cycle after it, `pending_o`, `txok_o` and `done_o` are all zero and `eng_valid_o` is low.
- R2: A request strobe `req_i[k]` on a mailbox that is not pending stores bit slice k of `req_id_i` (bits k*11 to k*11+10) as that mailbox's identifier. From the next cycle it sets `pending_o[k]` and clears `txok_o[k]` and `done_o[k]`. A strobe on a mailbox that is already pending is ignored, and its stored identifier is kept.
- R3: With `order_fifo` = 0, the pending mailbox with the numerically lowest identifier is offered first. Equal identifiers go to the lower mailbox index.
- R4: With `order_fifo` = 1, pending mailboxes are offered in the order their requests were accepted. Requests accepted in the same cycle count as earlier for the lower mailbox index.
- R5: `eng_valid_o` holds `eng_mb_o` and `eng_id_o` stable until the cycle in which `eng_ready_i` is high. After acceptance, no mailbox is offered until a completion arrives. A `cpl_valid_i` pulse given while no attempt has been accepted is ignored.
- R6: Completion status `cpl_status_i` uses 2'b00 for success, 2'b01 for error and 2'b10 for arbitration lost, and 2'b11 is handled as error. On success the mailbox of that attempt leaves pending and sets `txok_o` and `done_o` in the next cycle.
- R7: With `one_shot` = 0, an error or lost arbitration leaves the mailbox pending with `txok_o` and `done_o` low, and the mailbox is offered again.
- R8: With `one_shot` = 1, an error or lost arbitration clears `pending_o` of that mailbox and sets `done_o` with `txok_o` low, and the mailbox is not offered again.
- R9: The ordering mode is sampled when a mailbox is selected, which happens only while the engine is idle. Changing `order_fifo` while an attempt is in progress changes the next selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| order_fifo | input | 1 | 0: identifier priority, 1: request-age order |
| one_shot | input | 1 | 1: a single attempt per request |
| req_i | input | 3 | Per-mailbox request strobe |
| req_id_i | input | 33 | Per-mailbox identifier, 11 bits per mailbox, mailbox 0 in the low bits |
| eng_valid_o | output | 1 | A mailbox is offered to the engine |
| eng_ready_i | input | 1 | Engine accepts the offer |
| eng_mb_o | output | 2 | Index of the offered mailbox |
| eng_id_o | output | 11 | Identifier of the offered mailbox |
| cpl_valid_i | input | 1 | Engine reports the end of the accepted attempt |
| cpl_status_i | input | 2 | Attempt result: 00 success, 01 error, 10 arbitration lost |
| pending_o | output | 3 | Mailbox armed and waiting or in flight |
| txok_o | output | 3 | Last request of the mailbox was sent successfully |
| done_o | output | 3 | Mailbox has stopped being pending |

## Verification
Some behaviours are checked by assertions on every cycle. These are that an offer stays stable until it is taken, that an offered mailbox is always pending, that the selector never yields more than one winner, that a success flag is never set without the done flag, and that each completion outcome has its effect in the next cycle. Whether the winner is the right one can only be shown by the bench's scenarios. The bench runs every identifier pattern with ties, every arrival order, same-cycle arrivals, and a mode switch made mid-attempt. It computes the expected service order on its own and compares it with the sequence of offers.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
  typedef enum logic [1:0] {
    CPL_OK   = 2'b00,
    CPL_ERR  = 2'b01,
    CPL_LOST = 2'b10,
    CPL_RSVD = 2'b11
  } cpl_e;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'b00,
    ENG_OFFER = 2'b01,
    ENG_BUSY  = 2'b10
  } eng_st_e;
endpackage

// File: rtl/can_tx_mb_slot.sv
module can_tx_mb_slot #(
  parameter int ID_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [ID_W-1:0] req_id,
  input  logic            fin_ok,
  input  logic            fin_drop,
  output logic            pend,
  output logic            txok,
  output logic            done,
  output logic [ID_W-1:0] id
);
  logic            pend_q, txok_q, done_q, pend_d, txok_d, done_d;
  logic [ID_W-1:0] id_q;
  logic            accept;

  assign accept = req && !pend_q;

  always_comb begin
    pend_d = pend_q;
    txok_d = txok_q;
    done_d = done_q;
    if (accept) begin
      pend_d = 1'b1;
      txok_d = 1'b0;
      done_d = 1'b0;
    end else if (fin_ok) begin
      pend_d = 1'b0;
      txok_d = 1'b1;
      done_d = 1'b1;
    end else if (fin_drop) begin
      pend_d = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      txok_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      txok_q <= txok_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      id_q <= '0;
    else if (accept) id_q <= req_id;
  end

  assign pend = pend_q;
  assign txok = txok_q;
  assign done = done_q;
  assign id   = id_q;

  p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !pend) |=> (pend && !done && !txok && id == $past(req_id)));
  p_keep_id_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> (id == $past(id)));
  p_txok_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    txok |-> (done && !pend) || (!txok && pend));
  p_pend_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend && done));
endmodule

// File: rtl/can_tx_age.sv
module can_tx_age #(
  parameter int N = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        acc,
  output logic [N-1:0][N-1:0] older
);
  logic [N-1:0][N-1:0] old_q, old_d;

  always_comb begin
    old_d = old_q;
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        if (a != b) begin
          if (acc[a])      old_d[a][b] = acc[b] && (a < b);
          else if (acc[b]) old_d[a][b] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    old_q <= '0;
    else if (|acc) old_q <= old_d;
  end

  assign older = old_q;
endmodule

// File: rtl/can_tx_pick.sv
module can_tx_pick #(
  parameter int N     = 3,
  parameter int ID_W  = 11,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]           cand,
  input  logic [N-1:0][ID_W-1:0] ids,
  input  logic [N-1:0][N-1:0]    older,
  input  logic                   use_age,
  output logic [N-1:0]           win,
  output logic [IDX_W-1:0]       win_idx
);
  always_comb begin
    win = '0;
    for (int i = 0; i < N; i++) begin
      logic beats;
      beats = 1'b1;
      for (int j = 0; j < N; j++) begin
        if (j != i && cand[j]) begin
          if (use_age) beats = beats && older[i][j];
          else beats = beats && ((ids[i] < ids[j]) || ((ids[i] == ids[j]) && (i < j)));
        end
      end
      win[i] = cand[i] && beats;
    end
  end

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N; i++)
      if (win[i]) win_idx = IDX_W'(i);
  end
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched #(
  parameter int NUM_MB = 3,
  parameter int ID_W   = 11,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   order_fifo,
  input  logic                   one_shot,
  input  logic [NUM_MB-1:0]      req_i,
  input  logic [NUM_MB*ID_W-1:0] req_id_i,
  output logic                   eng_valid_o,
  input  logic                   eng_ready_i,
  output logic [IDX_W-1:0]       eng_mb_o,
  output logic [ID_W-1:0]        eng_id_o,
  input  logic                   cpl_valid_i,
  input  logic [1:0]             cpl_status_i,
  output logic [NUM_MB-1:0]      pending_o,
  output logic [NUM_MB-1:0]      txok_o,
  output logic [NUM_MB-1:0]      done_o
);
  import can_tx_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [NUM_MB-1:0][ID_W-1:0]   mb_id;
  logic [NUM_MB-1:0][NUM_MB-1:0] older;
  logic [NUM_MB-1:0]             win, fin_ok, fin_drop, acc;
  logic [IDX_W-1:0]              win_idx;

  eng_st_e          st_q, st_d;
  logic [IDX_W-1:0] sel_q, sel_d;
  logic [ID_W-1:0]  sel_id_q, sel_id_d;
  logic             sel_en, cpl_take, cpl_good;

  assign acc      = req_i & ~pending_o;
  assign cpl_take = (st_q == ENG_BUSY) && cpl_valid_i;
  assign cpl_good = (cpl_status_i == CPL_OK);

  for (genvar k = 0; k < NUM_MB; k++) begin : g_mb
    assign fin_ok[k]   = cpl_take && (sel_q == IDX_W'(k)) && cpl_good;
    assign fin_drop[k] = cpl_take && (sel_q == IDX_W'(k)) && !cpl_good && one_shot;

    can_tx_mb_slot #(.ID_W(ID_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .req      (req_i[k]),
      .req_id   (req_id_i[k*ID_W +: ID_W]),
      .fin_ok   (fin_ok[k]),
      .fin_drop (fin_drop[k]),
      .pend     (pending_o[k]),
      .txok     (txok_o[k]),
      .done     (done_o[k]),
      .id       (mb_id[k])
    );
  end

  can_tx_age #(.N(NUM_MB)) u_age (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .acc   (acc),
    .older (older)
  );

  can_tx_pick #(.N(NUM_MB), .ID_W(ID_W), .IDX_W(IDX_W)) u_pick (
    .cand    (pending_o),
    .ids     (mb_id),
    .older   (older),
    .use_age (order_fifo),
    .win     (win),
    .win_idx (win_idx)
  );

  always_comb begin
    st_d     = st_q;
    sel_d    = sel_q;
    sel_id_d = sel_id_q;
    sel_en   = 1'b0;
    case (st_q)
      ENG_IDLE: if (|pending_o) begin
        st_d     = ENG_OFFER;
        sel_en   = 1'b1;
        sel_d    = win_idx;
        sel_id_d = mb_id[win_idx];
      end
      ENG_OFFER: if (eng_ready_i) st_d = ENG_BUSY;
      ENG_BUSY:  if (cpl_valid_i) st_d = ENG_IDLE;
      default:   st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) st_q <= ENG_IDLE;
    else             st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q    <= '0;
      sel_id_q <= '0;
    end else if (sel_en) begin
      sel_q    <= sel_d;
      sel_id_q <= sel_id_d;
    end
  end

  assign eng_valid_o = (st_q == ENG_OFFER);
  assign eng_mb_o    = sel_q;
  assign eng_id_o    = sel_id_q;

  p_offer_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eng_valid_o && !eng_ready_i) |=>
      (eng_valid_o && $stable(eng_mb_o) && $stable(eng_id_o)));
  p_no_offer_in_flight_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eng_valid_o && eng_ready_i) |=> !eng_valid_o);
  p_offer_pending_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eng_valid_o |-> pending_o[eng_mb_o]);
  p_win_onehot_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(win) && ((|pending_o) == (|win)));
  p_success_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpl_take && cpl_good) |=> (!pending_o[$past(eng_mb_o)] && txok_o[$past(eng_mb_o)]));
  p_retry_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpl_take && !cpl_good && !one_shot) |=>
      (pending_o[$past(eng_mb_o)] && !done_o[$past(eng_mb_o)]));
  p_one_shot_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpl_take && !cpl_good && one_shot) |=>
      (!pending_o[$past(eng_mb_o)] && done_o[$past(eng_mb_o)] && !txok_o[$past(eng_mb_o)]));
endmodule

// File: tb/can_tx_sched_tb.sv
module can_tx_sched_tb_top;
  localparam int N = 3;
  localparam int W = 11;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         order_fifo = 1'b0, one_shot = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [W-1:0] idv [N];
  logic         eng_ready_i = 1'b0, cpl_valid_i = 1'b0;
  logic [1:0]   cpl_status_i = 2'b00;
  logic         eng_valid_o;
  logic [1:0]   eng_mb_o;
  logic [W-1:0] eng_id_o;
  logic [N-1:0] pending_o, txok_o, done_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  can_tx_sched dut_i (
    .clk (clk), .rst_n (rst_n), .order_fifo (order_fifo), .one_shot (one_shot),
    .req_i (req_i), .req_id_i ({idv[2], idv[1], idv[0]}),
    .eng_valid_o (eng_valid_o), .eng_ready_i (eng_ready_i),
    .eng_mb_o (eng_mb_o), .eng_id_o (eng_id_o),
    .cpl_valid_i (cpl_valid_i), .cpl_status_i (cpl_status_i),
    .pending_o (pending_o), .txok_o (txok_o), .done_o (done_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic request(logic [N-1:0] m);
    req_i = m;
    @(negedge clk);
    req_i = '0;
  endtask

  task automatic wait_offer();
    for (int n = 0; n < 50 && !eng_valid_o; n++) @(negedge clk);
  endtask

  task automatic serve(int emb, int eid, logic [1:0] st, string tag);
    wait_offer();
    chk({tag, " valid"}, int'(eng_valid_o), 1);
    chk({tag, " mb"}, int'(eng_mb_o), emb);
    chk({tag, " id"}, int'(eng_id_o), eid);
    eng_ready_i = 1'b1;
    @(negedge clk);
    eng_ready_i = 1'b0;
    cpl_valid_i = 1'b1;
    cpl_status_i = st;
    @(negedge clk);
    cpl_valid_i = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < N; k++) idv[k] = '0;
    repeat (3) @(negedge clk);
    chk("R1 pending in reset", int'(pending_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pending", int'(pending_o), 0);
    chk("R1 txok", int'(txok_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 valid", int'(eng_valid_o), 0);
    repeat (3) @(negedge clk);

    // R3: every identifier pattern from a three-value set, ties included
    begin
      logic [W-1:0] vals [3];
      vals[0] = 11'h010; vals[1] = 11'h3A0; vals[2] = 11'h7FF;
      order_fifo = 1'b0; one_shot = 1'b0;
      for (int c = 0; c < 27; c++) begin
        bit used [N];
        idv[0] = vals[c % 3]; idv[1] = vals[(c / 3) % 3]; idv[2] = vals[c / 9];
        request(3'b111);
        chk("R2 armed", int'(pending_o), 7);
        chk("R2 done cleared", int'(done_o), 0);
        for (int k = 0; k < N; k++) used[k] = 1'b0;
        for (int s = 0; s < N; s++) begin
          int best;
          best = -1;
          for (int k = 0; k < N; k++)
            if (!used[k] && (best < 0 || idv[k] < idv[best])) best = k;
          used[best] = 1'b1;
          serve(best, int'(idv[best]), 2'b00, "R3 id order");
          chk("R6 success txok", int'(txok_o[best]), 1);
        end
        chk("R6 all done", int'(done_o), 7);
        chk("R6 none pending", int'(pending_o), 0);
      end
    end

    // R4: every arrival order, later requests carry lower identifiers
    order_fifo = 1'b1;
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        if (a != b) begin
          int c3;
          c3 = 3 - a - b;
          idv[a] = 11'h700; idv[b] = 11'h600; idv[c3] = 11'h500;
          request(3'(1 << a));
          request(3'(1 << b));
          request(3'(1 << c3));
          serve(a, 11'h700, 2'b00, "R4 age first");
          serve(b, 11'h600, 2'b00, "R4 age second");
          serve(c3, 11'h500, 2'b00, "R4 age third");
        end
      end
    end
    // R4: same-cycle arrivals, lower index is older
    idv[0] = 11'h7FF; idv[1] = 11'h000; idv[2] = 11'h001;
    request(3'b101);
    request(3'b010);
    serve(0, 11'h7FF, 2'b00, "R4 same cycle a");
    serve(2, 11'h001, 2'b00, "R4 same cycle b");
    serve(1, 11'h000, 2'b00, "R4 same cycle c");

    // R9: mode changed while an attempt is in flight
    for (int m = 0; m < 2; m++) begin
      order_fifo = 1'b1;
      idv[2] = 11'h222;
      request(3'b100);
      wait_offer();
      eng_ready_i = 1'b1;
      @(negedge clk);
      eng_ready_i = 1'b0;
      idv[0] = 11'h400; request(3'b001);
      idv[1] = 11'h050; request(3'b010);
      order_fifo = m[0];
      cpl_valid_i = 1'b1; cpl_status_i = 2'b00;
      @(negedge clk);
      cpl_valid_i = 1'b0;
      if (m == 0) begin
        serve(1, 11'h050, 2'b00, "R9 switched to id mode");
        serve(0, 11'h400, 2'b00, "R9 id mode second");
      end else begin
        serve(0, 11'h400, 2'b00, "R9 age mode first");
        serve(1, 11'h050, 2'b00, "R9 age mode second");
      end
    end

    // R5: offer held, stray completion ignored, no offer while in flight
    order_fifo = 1'b0;
    idv[0] = 11'h123;
    request(3'b001);
    wait_offer();
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      chk("R5 hold valid", int'(eng_valid_o), 1);
      chk("R5 hold mb", int'(eng_mb_o), 0);
    end
    cpl_valid_i = 1'b1; cpl_status_i = 2'b00;
    @(negedge clk);
    cpl_valid_i = 1'b0;
    chk("R5 stray completion pending", int'(pending_o[0]), 1);
    chk("R5 stray completion txok", int'(txok_o[0]), 0);
    eng_ready_i = 1'b1;
    @(negedge clk);
    eng_ready_i = 1'b0;
    idv[1] = 11'h001;
    request(3'b010);
    repeat (3) @(negedge clk);
    chk("R5 no offer in flight", int'(eng_valid_o), 0);
    cpl_valid_i = 1'b1; cpl_status_i = 2'b00;
    @(negedge clk);
    cpl_valid_i = 1'b0;
    chk("R6 txok after success", int'(txok_o[0]), 1);
    serve(1, 11'h001, 2'b00, "R5 next after completion");

    // R7: retries with original identifier, strobe while pending ignored
    one_shot = 1'b0;
    idv[1] = 11'h155;
    request(3'b010);
    serve(1, 11'h155, 2'b01, "R7 error attempt");
    chk("R7 still pending", int'(pending_o[1]), 1);
    chk("R7 done low", int'(done_o[1]), 0);
    chk("R7 txok low", int'(txok_o[1]), 0);
    idv[1] = 11'h0AA;
    request(3'b010);
    serve(1, 11'h155, 2'b10, "R2 ignored strobe keeps id");
    chk("R7 pending after lost", int'(pending_o[1]), 1);
    serve(1, 11'h155, 2'b11, "R7 reserved status as error");
    chk("R7 pending after code 3", int'(pending_o[1]), 1);
    serve(1, 11'h155, 2'b00, "R7 final success");
    chk("R7 txok", int'(txok_o[1]), 1);

    // R8: single attempt, both failure kinds
    one_shot = 1'b1;
    idv[0] = 11'h100; idv[2] = 11'h080;
    request(3'b101);
    serve(2, 11'h080, 2'b01, "R8 first");
    chk("R8 error pending", int'(pending_o[2]), 0);
    chk("R8 error done", int'(done_o[2]), 1);
    chk("R8 error txok", int'(txok_o[2]), 0);
    chk("R8 other still pending", int'(pending_o[0]), 1);
    serve(0, 11'h100, 2'b10, "R8 second");
    chk("R8 lost pending", int'(pending_o[0]), 0);
    chk("R8 lost done", int'(done_o[0]), 1);
    chk("R8 lost txok", int'(txok_o[0]), 0);
    repeat (5) @(negedge clk);
    chk("R8 no further offer", int'(eng_valid_o), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule